// File: doc/BRIEF.md
# Dual-Protocol Serial Control Front End for a Two-Channel Current DAC

This block is the digital control path of a two-channel, 10-bit current-output converter. It decodes 16-bit command words that arrive over one set of shared serial pins and holds the settings those commands produce. A static strap chooses the bus protocol. With the strap high, the pins act as a four-wire shift port with an active-low select and a serial output. That output can feed a second device in a chain, or it can return the previous word. With the strap low, the pins act as a two-wire addressed bus. The block is a write-only slave there, and two strap pins set the low address bits.

All pins are sampled by the system clock through synchronizers, so serial edges must be several clocks apart. Every decoded word goes to one command decoder. The decoder keeps a staging register for each channel and a live code register for each channel. It also drives the reference source select, a two-bit full-scale range select and a power-down flag. The serial path stays active during power-down.

The outputs are plain control levels with no handshake. The serial pins set the command rate: one word per frame. The block never stalls the sender. The only response it gives on the two-wire bus is the acknowledge bit.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both channel codes are 0, `ref_internal` is 0 (external reference), `range_sel` is 0 (lowest range), `shutdown` is 0, and `dout_en` and `sda_pull_low` are both 0.
- R2: In shift mode (`mode_spi`=1), a word is taken MSB first on rising serial-clock edges while `cs_a0` is low. It is decoded when `cs_a0` rises. Bits [15:12] hold the command and bits [11:2] hold the 10-bit code.
- R3: A shift-mode frame with any count of rising edges other than 16 between the falling and rising select edges changes no output.
- R4: `dout_en` is 1 only in shift mode while `cs_a0` is low. During a frame, `dout` first shows bit 15 of the previous shift-register content and then moves one bit lower on each falling serial-clock edge, so the previous 16-bit word comes out MSB first.
- R5: In two-wire mode (`mode_spi`=0), the block pulls the data line low for the acknowledge bit after an address byte equal to 0,1,1,1,0,`dout_a1`,`cs_a0`,0 (write). After any other address byte it gives no acknowledge and ignores the rest of the transfer.
- R6: After an acknowledged address, the block acknowledges two data bytes, the upper byte first. It decodes the 16-bit word when the second byte completes.
- R7: Command 4 sets `ref_internal` from bit 11 and `range_sel` from bits [10:9].
- R8: Command 5 sets `shutdown` and command 6 clears it. Load and transfer commands still take effect while `shutdown` is 1.
- R9: The protocol that is not selected has no effect. In two-wire mode, shift-mode traffic changes no output and `dout_en` stays 0. In shift mode, two-wire traffic changes no output and `sda_pull_low` stays 0.
- R10: Commands 1 and 2 write only the staging register of channel A or B. Command 3 copies both staging registers to `dac_a` and `dac_b` in the same cycle. The channel codes change at no other time. Commands 0 and 7 to 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_spi | input | 1 | Static protocol strap: 1 = shift mode, 0 = two-wire mode |
| sclk_scl | input | 1 | Serial clock (both modes) |
| din_sda | input | 1 | Serial data in; two-wire mode: resolved data-line level |
| cs_a0 | input | 1 | Active-low select (shift mode) / address bit 0 (two-wire mode) |
| dout_a1 | input | 1 | Address bit 1 strap sampled from the shared pin (two-wire mode) |
| dout | output | 1 | Serial data out for chaining and readback |
| dout_en | output | 1 | Output enable of `dout` |
| sda_pull_low | output | 1 | Open-drain pull-down of the two-wire data line (acknowledge) |
| dac_a | output | 10 | Live code of channel A (offset binary) |
| dac_b | output | 10 | Live code of channel B (offset binary) |
| ref_internal | output | 1 | 1 = internal reference, 0 = external |
| range_sel | output | 2 | Full-scale current range select |
| shutdown | output | 1 | Power-down request |

## Verification
In shift mode, one rising serial-clock edge captures a new bit into the shift register. The same register then supplies the outgoing bit on the next falling edge. Capture of the new word and delivery of the old word therefore overlap over the whole frame. The bench sends one known word and then sends a second word. During the second frame it samples `dout` just before each rising edge and compares the sixteen samples with the first word. After the select rises, it checks the outputs against the effect of the second word.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP   = 4'd0,
    CMD_LD_A  = 4'd1,
    CMD_LD_B  = 4'd2,
    CMD_XFER  = 4'd3,
    CMD_CFG   = 4'd4,
    CMD_SLEEP = 4'd5,
    CMD_WAKE  = 4'd6
  } dacfe_cmd_e;

  typedef enum logic [2:0] {
    TW_IDLE, TW_ADDR, TW_ACKA, TW_BYTE1, TW_ACK1, TW_BYTE2, TW_ACK2
  } tw_state_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [STAGES-1:0][W-1:0] st;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= RST_VAL;
        else        st <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= {STAGES{RST_VAL}};
        else        st <= {st[STAGES-2:0], d};
    end
  endgenerate

  assign q = st[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_d <= RST_VAL;
    else        q_d <= q;
endmodule

// File: rtl/dacfe_spi_rx.sv
module dacfe_spi_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk,
  input  logic              sclk_d,
  input  logic              din,
  input  logic              cs_n,
  input  logic              cs_n_d,
  output logic              frm_vld,
  output logic [WORD_W-1:0] frm_word,
  output logic              dout,
  output logic              dout_en
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              dout_q;

  wire cs_fall = en && cs_n_d && !cs_n;
  wire cs_rise = en && !cs_n_d && cs_n;
  wire clk_up  = en && !cs_n && !sclk_d && sclk;
  wire clk_dn  = en && !cs_n && sclk_d && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      dout_q  <= 1'b0;
      frm_vld <= 1'b0;
    end else begin
      frm_vld <= 1'b0;
      if (cs_fall) begin
        cnt    <= '0;
        dout_q <= shreg[WORD_W-1];
      end else if (cs_rise) begin
        frm_vld <= (cnt == CNT_FULL);
      end else begin
        if (clk_up) begin
          shreg <= {shreg[WORD_W-2:0], din};
          if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
        if (clk_dn) dout_q <= shreg[WORD_W-1];
      end
    end
  end

  assign frm_word = shreg;
  assign dout     = dout_q;
  assign dout_en  = en && !cs_n;
endmodule

// File: rtl/dacfe_tw_rx.sv
module dacfe_tw_rx
  import dacfe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [4:0] ADDR_PREFIX = 5'b01110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl,
  input  logic              scl_d,
  input  logic              sda,
  input  logic              sda_d,
  input  logic              a0,
  input  logic              a1,
  output logic              frm_vld,
  output logic [WORD_W-1:0] frm_word,
  output logic              pull_low
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int BC_W   = $clog2(BYTE_W + 1);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(BYTE_W);

  tw_state_e         state;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] hi;
  logic [BC_W-1:0]   bcnt;

  wire rise  = !scl_d && scl;
  wire fall  = scl_d && !scl;
  wire start = scl && scl_d && sda_d && !sda;
  wire stop  = scl && scl_d && !sda_d && sda;
  wire addr_ok = (sh[BYTE_W-1:1] == {ADDR_PREFIX, a1, a0}) && !sh[0];
  wire in_byte = (state == TW_ADDR) || (state == TW_BYTE1) || (state == TW_BYTE2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TW_IDLE;
      sh       <= '0;
      hi       <= '0;
      bcnt     <= '0;
      pull_low <= 1'b0;
      frm_vld  <= 1'b0;
      frm_word <= '0;
    end else begin
      frm_vld <= 1'b0;
      if (!en) begin
        state    <= TW_IDLE;
        pull_low <= 1'b0;
      end else if (start) begin
        state    <= TW_ADDR;
        bcnt     <= '0;
        pull_low <= 1'b0;
      end else if (stop) begin
        state    <= TW_IDLE;
        pull_low <= 1'b0;
      end else if (in_byte) begin
        if (rise) begin
          sh   <= {sh[BYTE_W-2:0], sda};
          bcnt <= bcnt + 1'b1;
        end else if (fall && bcnt == BC_FULL) begin
          bcnt <= '0;
          case (state)
            TW_ADDR: begin
              if (addr_ok) begin
                pull_low <= 1'b1;
                state    <= TW_ACKA;
              end else begin
                state <= TW_IDLE;
              end
            end
            TW_BYTE1: begin
              hi       <= sh;
              pull_low <= 1'b1;
              state    <= TW_ACK1;
            end
            default: begin
              frm_word <= {hi, sh};
              frm_vld  <= 1'b1;
              pull_low <= 1'b1;
              state    <= TW_ACK2;
            end
          endcase
        end
      end else if (fall) begin
        pull_low <= 1'b0;
        case (state)
          TW_ACKA: state <= TW_BYTE1;
          TW_ACK1: state <= TW_BYTE2;
          default: state <= TW_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CODE_W  = 10,
  parameter int RANGE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic [WORD_W-1:0] frm_word,
  output logic [CODE_W-1:0] dac_a,
  output logic [CODE_W-1:0] dac_b,
  output logic              ref_internal,
  output logic [RANGE_W-1:0] range_sel,
  output logic              shutdown
);
  localparam int PAY_HI = WORD_W - CMD_W - 1;
  localparam int RNG_HI = PAY_HI - 1;

  logic [CMD_W-1:0]  cmd;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] stage_a, stage_b;

  assign cmd  = frm_word[WORD_W-1 -: CMD_W];
  assign code = frm_word[PAY_HI -: CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a      <= '0;
      stage_b      <= '0;
      dac_a        <= '0;
      dac_b        <= '0;
      ref_internal <= 1'b0;
      range_sel    <= '0;
      shutdown     <= 1'b0;
    end else if (frm_vld) begin
      case (cmd)
        CMD_LD_A:  stage_a <= code;
        CMD_LD_B:  stage_b <= code;
        CMD_XFER: begin
          dac_a <= stage_a;
          dac_b <= stage_b;
        end
        CMD_CFG: begin
          ref_internal <= frm_word[PAY_HI];
          range_sel    <= frm_word[RNG_HI -: RANGE_W];
        end
        CMD_SLEEP: shutdown <= 1'b1;
        CMD_WAKE:  shutdown <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacfe_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CODE_W      = 10,
  parameter int RANGE_W     = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b01110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_spi,
  input  logic               sclk_scl,
  input  logic               din_sda,
  input  logic               cs_a0,
  input  logic               dout_a1,
  output logic               dout,
  output logic               dout_en,
  output logic               sda_pull_low,
  output logic [CODE_W-1:0]  dac_a,
  output logic [CODE_W-1:0]  dac_b,
  output logic               ref_internal,
  output logic [RANGE_W-1:0] range_sel,
  output logic               shutdown
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pin_q, pin_qd;
  logic spi_vld, tw_vld, frame_vld;
  logic [WORD_W-1:0] spi_word, tw_word, frame_word;

  dacfe_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_a0, din_sda, sclk_scl}),
    .q(pin_q), .q_d(pin_qd)
  );

  dacfe_spi_rx #(.WORD_W(WORD_W)) u_spi (
    .clk(clk), .rst_n(rst_n), .en(mode_spi),
    .sclk(pin_q[0]), .sclk_d(pin_qd[0]),
    .din(pin_q[1]),
    .cs_n(pin_q[2]), .cs_n_d(pin_qd[2]),
    .frm_vld(spi_vld), .frm_word(spi_word),
    .dout(dout), .dout_en(dout_en)
  );

  dacfe_tw_rx #(.WORD_W(WORD_W), .ADDR_PREFIX(ADDR_PREFIX)) u_tw (
    .clk(clk), .rst_n(rst_n), .en(!mode_spi),
    .scl(pin_q[0]), .scl_d(pin_qd[0]),
    .sda(pin_q[1]), .sda_d(pin_qd[1]),
    .a0(pin_q[2]), .a1(dout_a1),
    .frm_vld(tw_vld), .frm_word(tw_word),
    .pull_low(sda_pull_low)
  );

  assign frame_vld  = mode_spi ? spi_vld : tw_vld;
  assign frame_word = mode_spi ? spi_word : tw_word;

  dacfe_regs #(.WORD_W(WORD_W), .CODE_W(CODE_W), .RANGE_W(RANGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .frm_vld(frame_vld), .frm_word(frame_word),
    .dac_a(dac_a), .dac_b(dac_b),
    .ref_internal(ref_internal), .range_sel(range_sel),
    .shutdown(shutdown)
  );
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dacfe_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CODE_W  = 10,
  parameter int RANGE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_spi,
  input logic               dout_en,
  input logic               sda_pull_low,
  input logic               frm_vld,
  input logic [WORD_W-1:0]  frm_word,
  input logic [CODE_W-1:0]  dac_a,
  input logic [CODE_W-1:0]  dac_b,
  input logic               ref_internal,
  input logic [RANGE_W-1:0] range_sel,
  input logic               shutdown
);
  localparam int PAY_HI = WORD_W - CMD_W - 1;
  logic [CMD_W-1:0] cmd;
  assign cmd = frm_word[WORD_W-1 -: CMD_W];

  // R2: a decoded word is a single-cycle event
  p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> !frm_vld);

  // R10: channel codes move only on a transfer command
  p_dac_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_vld && cmd == CMD_XFER) |=> $stable(dac_a) && $stable(dac_b));

  // R7: configuration fields land in the control outputs
  p_cfg_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && cmd == CMD_CFG) |=>
      (ref_internal == $past(frm_word[PAY_HI])) &&
      (range_sel == $past(frm_word[PAY_HI-1 -: RANGE_W])));

  // R8: power-down entry and exit
  p_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && cmd == CMD_SLEEP) |=> shutdown);
  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && cmd == CMD_WAKE) |=> !shutdown);

  // R4: serial output only drives in shift mode
  p_dout_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_spi |-> !dout_en);

  // R9: no acknowledge pull in shift mode
  p_no_pull_spi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_spi |-> !sda_pull_low);
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(
  .WORD_W(WORD_W), .CODE_W(CODE_W), .RANGE_W(RANGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi),
  .dout_en(dout_en), .sda_pull_low(sda_pull_low),
  .frm_vld(frame_vld), .frm_word(frame_word),
  .dac_a(dac_a), .dac_b(dac_b),
  .ref_internal(ref_internal), .range_sel(range_sel),
  .shutdown(shutdown)
);

// File: tb/dual_dac_ctrl_test.sv
`timescale 1ns/1ps
module dual_dac_ctrl_test;
  localparam int H = 8;
  localparam int NV = 12;
  localparam logic [6:0] MY_ADDR = 7'h39;

  // {spi, word[15:0], exp_a[9:0], exp_b[9:0], exp_ref, exp_rng[1:0], exp_sd}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 16'h1554, 10'h000, 10'h000, 1'b0, 2'd0, 1'b0}, // R10 load A only
    {1'b1, 16'h2AA8, 10'h000, 10'h000, 1'b0, 2'd0, 1'b0}, // R10 load B only
    {1'b1, 16'h3000, 10'h155, 10'h2AA, 1'b0, 2'd0, 1'b0}, // R2 R10 transfer
    {1'b0, 16'h1FFC, 10'h155, 10'h2AA, 1'b0, 2'd0, 1'b0}, // R6 load A
    {1'b0, 16'h3000, 10'h3FF, 10'h2AA, 1'b0, 2'd0, 1'b0}, // R6 transfer
    {1'b1, 16'h4A00, 10'h3FF, 10'h2AA, 1'b1, 2'd1, 1'b0}, // R7 config
    {1'b0, 16'h5000, 10'h3FF, 10'h2AA, 1'b1, 2'd1, 1'b1}, // R8 sleep
    {1'b1, 16'h2004, 10'h3FF, 10'h2AA, 1'b1, 2'd1, 1'b1}, // R8 load in sleep
    {1'b0, 16'h3000, 10'h3FF, 10'h001, 1'b1, 2'd1, 1'b1}, // R8 transfer in sleep
    {1'b1, 16'h6000, 10'h3FF, 10'h001, 1'b1, 2'd1, 1'b0}, // R8 wake
    {1'b1, 16'hF123, 10'h3FF, 10'h001, 1'b1, 2'd1, 1'b0}, // R10 unused command
    {1'b0, 16'h4600, 10'h3FF, 10'h001, 1'b0, 2'd3, 1'b0}  // R7 config
  };

  logic clk = 0, rst_n = 0;
  logic mode_spi = 1, sclk_scl = 1, bench_sda = 1, cs_a0 = 1, dout_a1 = 0;
  logic din_sda, dout, dout_en, sda_pull_low, ref_internal, shutdown;
  logic [9:0] dac_a, dac_b;
  logic [1:0] range_sel;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;
  assign din_sda = bench_sda & ~sda_pull_low;

  dual_dac_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi), .sclk_scl(sclk_scl),
    .din_sda(din_sda), .cs_a0(cs_a0), .dout_a1(dout_a1), .dout(dout),
    .dout_en(dout_en), .sda_pull_low(sda_pull_low), .dac_a(dac_a),
    .dac_b(dac_b), .ref_internal(ref_internal), .range_sel(range_sel),
    .shutdown(shutdown)
  );

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_send(input logic [31:0] w, input int n, output logic [15:0] cap, output logic en_seen);
    cap = '0;
    cs_a0 = 0; sclk_scl = 0; wt(H);
    en_seen = dout_en;
    for (int i = 0; i < n; i++) begin
      bench_sda = w[n-1-i]; wt(H);
      if (i < 16) cap[15-i] = dout;
      sclk_scl = 1; wt(H);
      sclk_scl = 0; wt(H);
    end
    cs_a0 = 1; wt(H);
    bench_sda = 1; wt(H);
    sclk_scl = 1; wt(4*H);
  endtask

  task automatic tw_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      bench_sda = b[i]; wt(H);
      sclk_scl = 1; wt(H);
      sclk_scl = 0; wt(H);
    end
    bench_sda = 1; wt(H);
    sclk_scl = 1; wt(H/2);
    ack = sda_pull_low; wt(H/2);
    sclk_scl = 0; wt(H);
  endtask

  task automatic tw_send(input logic [6:0] addr, input logic [15:0] w, output int acks);
    logic a;
    acks = 0;
    bench_sda = 1; sclk_scl = 1; wt(H);
    bench_sda = 0; wt(H);
    sclk_scl = 0; wt(H);
    tw_byte({addr, 1'b0}, a); acks += int'(a);
    tw_byte(w[15:8], a);      acks += int'(a);
    tw_byte(w[7:0], a);       acks += int'(a);
    bench_sda = 0; wt(H);
    sclk_scl = 1; wt(H);
    bench_sda = 1; wt(4*H);
  endtask

  task automatic expect_state(input string tag, input logic [9:0] a, input logic [9:0] b,
                              input logic rf, input logic [1:0] rg, input logic sd);
    chk(dac_a == a, {tag, " dac_a"}, 32'(dac_a), 32'(a));
    chk(dac_b == b, {tag, " dac_b"}, 32'(dac_b), 32'(b));
    chk(ref_internal == rf, {tag, " ref_internal"}, 32'(ref_internal), 32'(rf));
    chk(range_sel == rg, {tag, " range_sel"}, 32'(range_sel), 32'(rg));
    chk(shutdown == sd, {tag, " shutdown"}, 32'(shutdown), 32'(sd));
  endtask

  initial begin
    logic [15:0] cap;
    logic en_seen;
    int acks;
    wt(5);
    rst_n = 1; wt(5);
    // R1 reset state
    expect_state("R1 reset", 10'h0, 10'h0, 1'b0, 2'd0, 1'b0);
    chk(!dout_en, "R1 dout_en", 32'(dout_en), 0);
    chk(!sda_pull_low, "R1 sda_pull_low", 32'(sda_pull_low), 0);

    // Table walk: R2 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      logic [40:0] e;
      e = VEC[v];
      if (e[40]) begin
        mode_spi = 1; wt(4);
        spi_send(32'(e[39:24]), 16, cap, en_seen);
      end else begin
        mode_spi = 0; wt(4);
        tw_send(MY_ADDR, e[39:24], acks);
        chk(acks == 3, $sformatf("R5 R6 acknowledges vector %0d", v), 32'(acks), 3);
      end
      wt(10);
      expect_state($sformatf("R2 R7 R8 R10 table vector %0d", v), e[23:14], e[13:4], e[3], e[2:1], e[0]);
    end

    // R3 short and long frames discarded (would set ref=1 range=1)
    mode_spi = 1; wt(4);
    spi_send(32'h2500, 15, cap, en_seen); wt(10);
    expect_state("R3 15-edge frame", 10'h3FF, 10'h001, 1'b0, 2'd3, 1'b0);
    spi_send(32'h04A00, 17, cap, en_seen); wt(10);
    expect_state("R3 17-edge frame", 10'h3FF, 10'h001, 1'b0, 2'd3, 1'b0);

    // R5 wrong address: no acknowledge, no effect
    mode_spi = 0; wt(4);
    tw_send(7'h3A, 16'h4A00, acks); wt(10);
    chk(acks == 0, "R5 wrong address acks", 32'(acks), 0);
    expect_state("R5 wrong address", 10'h3FF, 10'h001, 1'b0, 2'd3, 1'b0);

    // R9 shift-mode traffic while in two-wire mode
    spi_send(32'h4A00, 16, cap, en_seen); wt(10);
    chk(!en_seen && !dout_en, "R9 dout_en in two-wire mode", 32'(en_seen), 0);
    expect_state("R9 shift traffic ignored", 10'h3FF, 10'h001, 1'b0, 2'd3, 1'b0);

    // R9 two-wire traffic while in shift mode
    mode_spi = 1; wt(4);
    tw_send(MY_ADDR, 16'h4A00, acks); wt(10);
    chk(acks == 0, "R9 no acknowledge in shift mode", 32'(acks), 0);
    expect_state("R9 two-wire traffic ignored", 10'h3FF, 10'h001, 1'b0, 2'd3, 1'b0);

    // R4 readback/daisy chain: second frame returns the first word
    spi_send(32'h0A5C, 16, cap, en_seen); wt(10);
    spi_send(32'h4C00, 16, cap, en_seen); wt(10);
    chk(cap == 16'h0A5C, "R4 dout stream", 32'(cap), 32'h0A5C);
    chk(en_seen, "R4 dout_en during frame", 32'(en_seen), 1);
    chk(!dout_en, "R4 dout_en after frame", 32'(dout_en), 0);
    expect_state("R4 R7 word after readback", 10'h3FF, 10'h001, 1'b1, 2'd2, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule